// File: doc/BRIEF.md
# Contactless Card Poll and Read-Block Responder

This block answers a reader on the card side of a contactless link. It sits between a frame receiver and a frame transmitter. The receiver passes it every byte of an incoming frame, from the length byte onward, and then marks the end of the frame together with the result of its CRC check. The responder keeps the length byte, the command byte and the request-code byte of the frame. When the frame ends with a good CRC, it decides whether the frame is a poll request or a read-block request. If the frame asks for a reply, the responder streams the reply out byte by byte.

Every reply is built on the fly, with no frame buffer. It starts with its length byte and then the reply command byte. Next comes an 8-byte card identifier, taken from the `id_value` input at the moment the reply is chosen. After that comes a fixed payload, and a 16-bit CRC closes the reply. The CRC is computed while the bytes go out.

Once the transmitter has taken the last byte and reports that it is done, the responder returns to listening and sends a one-cycle re-arm pulse to the receiver. A frame that is rejected also produces this pulse.

Top module: `poll_read_responder`

## Requirements
- R1: After reset, `tx_valid` and `rx_rearm` are both low.
- R2: A frame with a good CRC, length byte 6, command byte 0x00 and request code 0 (byte index 4, with the length byte at index 0) is answered with 20 bytes. These are: 0x12, 0x01, the eight identifier bytes most significant first, then 00 F1 00 00 00 01 43 00, then the CRC.
- R3: A poll request with request code 1 produces no transmission by default. The responder stays listening and pulses `rx_rearm`. With `SYSCODE_REPLY`=1 it instead answers with 22 bytes: 0x14, 0x01, the identifier, the same eight parameter bytes, the system code 0x88 0xB4, then the CRC.
- R4: A frame with a good CRC, command byte 0x06 and length byte greater than 5 is answered with 31 bytes. These are: 0x1D, 0x07, the identifier, status 00 00, block count 01, sixteen data bytes of value 0 to 15 in order, then the CRC.
- R5: The last two reply bytes are the CRC-16 over the reply from its length byte to the end of its payload, high byte first. The CRC uses polynomial 0x1021 and initial value 0x0000, and each byte is taken most significant bit first.
- R6: A frame is dropped without any transmission, and `rx_rearm` is high in the cycle after `rx_end`, in each of these cases: the CRC is bad, the command is not recognised, the poll length is not 6, the poll request code is 2 or more, or a read-block frame has a length byte of 5 or less.
- R7: While `tx_ready` is low, `tx_byte` and `tx_last` hold their values. A byte is consumed when `tx_valid` and `tx_ready` are both high. `tx_last` marks the final CRC byte.
- R8: The identifier is captured when the reply is chosen. Later changes on `id_value` do not alter a reply that is already going out.
- R9: After the final byte is accepted, `tx_valid` stays low until `tx_done`. `tx_done` returns the block to listening and pulses `rx_rearm` in the next cycle. Receiver bytes and frame ends that arrive while a reply is pending are ignored, including a frame end in the same cycle as `tx_done`.
- R10: The first reply byte is presented on `tx_valid` in the cycle right after the `rx_end` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received frame byte is present on rx_byte |
| rx_byte | input | 8 | Received byte, length byte first |
| rx_end | input | 1 | End of the received frame |
| rx_crc_ok | input | 1 | The receiver found the frame CRC good; valid with rx_end |
| id_value | input | 64 | Card identifier, most significant byte sent first |
| tx_ready | input | 1 | The transmitter accepts the byte on tx_byte |
| tx_done | input | 1 | The transmitter has finished sending the reply |
| tx_valid | output | 1 | A reply byte is present on tx_byte |
| tx_byte | output | 8 | Reply byte |
| tx_last | output | 1 | The byte on tx_byte is the final reply byte |
| rx_rearm | output | 1 | One-cycle pulse that clears the receiver for the next frame |

## Verification
Two events can meet in one cycle: the transmitter's completion and the receiver's end-of-frame. The bench provokes this in two steps. While a reply is waiting for completion, it feeds in a complete, well-formed poll request. It then raises `tx_done` in the same cycle as that frame's `rx_end` with a good CRC. The correct outcome has three parts: a single re-arm pulse, no new reply in the following cycles, and normal answers to the frames that come afterwards. A second instance built with the system-code option runs alongside the default one. This lets the request-code-1 case show both the silent re-arm and the long reply in the same cycle.

// File: rtl/prr_pkg.sv
package prr_pkg;

    // Field sizes of the reply frames
    localparam int ID_BYTES   = 8;
    localparam int PRM_BYTES  = 8;
    localparam int SYS_BYTES  = 2;
    localparam int STAT_BYTES = 3;
    localparam int BLK_BYTES  = 16;
    localparam int ID_W       = 8 * ID_BYTES;

    // Length byte values (length byte through end of payload)
    localparam int LEN_SHORT  = 2 + ID_BYTES + PRM_BYTES;
    localparam int LEN_LONG   = LEN_SHORT + SYS_BYTES;
    localparam int LEN_READ   = 2 + ID_BYTES + STAT_BYTES + BLK_BYTES;
    localparam int POS_W      = 6;
    localparam int SEEN_W     = 3;

    // Command and header constants
    localparam logic [7:0] CMD_POLL_REQ = 8'h00;
    localparam logic [7:0] CMD_POLL_RSP = 8'h01;
    localparam logic [7:0] CMD_READ_REQ = 8'h06;
    localparam logic [7:0] CMD_READ_RSP = 8'h07;
    localparam logic [7:0] POLL_LEN     = 8'd6;
    localparam logic [7:0] READ_LEN_MIN = 8'd5;
    localparam int         IDX_LEN      = 0;
    localparam int         IDX_CMD      = 1;
    localparam int         IDX_CODE     = 4;

    typedef enum logic [1:0] {
        RK_NONE       = 2'd0,
        RK_POLL_SHORT = 2'd1,
        RK_POLL_LONG  = 2'd2,
        RK_READ       = 2'd3
    } rkind_t;

    typedef enum logic [1:0] {
        ST_LISTEN = 2'd0,
        ST_SEND   = 2'd1,
        ST_WAIT   = 2'd2
    } rstate_t;

    // One byte of CRC-16, polynomial 0x1021, MSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] b);
        logic [15:0] c;
        c = crc ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rsp_decode.sv
module rsp_decode
    import prr_pkg::*;
#(
    parameter bit SYSCODE_REPLY = 1'b0
) (
    input  logic [7:0]        hdr_len,
    input  logic [7:0]        hdr_cmd,
    input  logic [7:0]        hdr_code,
    input  logic [SEEN_W-1:0] hdr_seen,
    output rkind_t            kind
);

    logic poll_hdr;
    logic read_hdr;

    always_comb begin
        poll_hdr = (int'(hdr_seen) > IDX_CODE) && (hdr_len == POLL_LEN) && (hdr_cmd == CMD_POLL_REQ);
        read_hdr = (int'(hdr_seen) > IDX_CMD) && (hdr_cmd == CMD_READ_REQ) && (hdr_len > READ_LEN_MIN);
        kind = RK_NONE;
        if (poll_hdr) begin
            if (hdr_code == 8'd0) begin
                kind = RK_POLL_SHORT;
            end else if (hdr_code == 8'd1 && SYSCODE_REPLY) begin
                kind = RK_POLL_LONG;
            end
        end else if (read_hdr) begin
            kind = RK_READ;
        end
    end

endmodule

// File: rtl/rsp_bytes.sv
module rsp_bytes
    import prr_pkg::*;
#(
    parameter logic [8*SYS_BYTES-1:0] SYS_CODE    = 16'h88B4,
    parameter logic [8*PRM_BYTES-1:0] POLL_PARAMS = 64'h00F1_0000_0001_4300
) (
    input  rkind_t           kind,
    input  logic [POS_W-1:0] pos,
    input  logic [ID_W-1:0]  id,
    input  logic [15:0]      crc,
    output logic [7:0]       data,
    output logic [POS_W-1:0] body_len,
    output logic [POS_W-1:0] last_pos
);

    localparam int PAY_START = 2 + ID_BYTES;

    int body;
    int p;
    int ip;

    always_comb begin
        case (kind)
            RK_POLL_SHORT: body = LEN_SHORT;
            RK_POLL_LONG:  body = LEN_LONG;
            RK_READ:       body = LEN_READ;
            default:       body = LEN_SHORT;
        endcase
        body_len = POS_W'(body);
        last_pos = POS_W'(body + 1);

        p    = int'(pos) - PAY_START;
        ip   = int'(pos) - 2;
        data = 8'h00;
        if (int'(pos) == 0) begin
            data = 8'(body);
        end else if (int'(pos) == 1) begin
            data = (kind == RK_READ) ? CMD_READ_RSP : CMD_POLL_RSP;
        end else if (int'(pos) < PAY_START) begin
            data = id[8*(ID_BYTES-1-ip) +: 8];
        end else if (int'(pos) < body) begin
            if (kind == RK_READ) begin
                if (p < STAT_BYTES - 1) begin
                    data = 8'h00;
                end else if (p == STAT_BYTES - 1) begin
                    data = 8'h01;
                end else begin
                    data = 8'(p - STAT_BYTES);
                end
            end else if (p < PRM_BYTES) begin
                data = POLL_PARAMS[8*(PRM_BYTES-1-p) +: 8];
            end else begin
                data = SYS_CODE[8*(SYS_BYTES-1-(p-PRM_BYTES)) +: 8];
            end
        end else if (int'(pos) == body) begin
            data = crc[15:8];
        end else begin
            data = crc[7:0];
        end
    end

endmodule

// File: rtl/rsp_crc16.sv
module rsp_crc16
    import prr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    logic [15:0] crc_d;
    logic [15:0] crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d = 16'h0000;
        end else if (en) begin
            crc_d = crc16_step(crc_q, din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= 16'h0000;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/poll_read_responder.sv
module poll_read_responder
    import prr_pkg::*;
#(
    parameter bit                     SYSCODE_REPLY = 1'b0,
    parameter logic [8*SYS_BYTES-1:0] SYS_CODE      = 16'h88B4,
    parameter logic [8*PRM_BYTES-1:0] POLL_PARAMS   = 64'h00F1_0000_0001_4300
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  logic [7:0]      rx_byte,
    input  logic            rx_end,
    input  logic            rx_crc_ok,
    input  logic [ID_W-1:0] id_value,
    input  logic            tx_ready,
    input  logic            tx_done,
    output logic            tx_valid,
    output logic [7:0]      tx_byte,
    output logic            tx_last,
    output logic            rx_rearm
);

    typedef struct packed {
        rstate_t           st;
        rkind_t            kind;
        logic [POS_W-1:0]  pos;
        logic [ID_W-1:0]   id;
        logic [7:0]        hlen;
        logic [7:0]        hcmd;
        logic [7:0]        hcode;
        logic [SEEN_W-1:0] seen;
        logic              rearm;
    } regs_t;

    localparam logic [SEEN_W-1:0] SEEN_MAX = '1;

    regs_t r_d;
    regs_t r_q;

    rkind_t           dec_kind;
    logic [7:0]       gen_byte;
    logic [POS_W-1:0] gen_body;
    logic [POS_W-1:0] gen_last;
    logic [15:0]      crc_val;
    logic             crc_clr;
    logic             crc_en;

    rsp_decode #(
        .SYSCODE_REPLY(SYSCODE_REPLY)
    ) u_decode (
        .hdr_len  (r_q.hlen),
        .hdr_cmd  (r_q.hcmd),
        .hdr_code (r_q.hcode),
        .hdr_seen (r_q.seen),
        .kind     (dec_kind)
    );

    rsp_bytes #(
        .SYS_CODE    (SYS_CODE),
        .POLL_PARAMS (POLL_PARAMS)
    ) u_bytes (
        .kind     (r_q.kind),
        .pos      (r_q.pos),
        .id       (r_q.id),
        .crc      (crc_val),
        .data     (gen_byte),
        .body_len (gen_body),
        .last_pos (gen_last)
    );

    rsp_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (gen_byte),
        .crc   (crc_val)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rearm = 1'b0;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        case (r_q.st)
            ST_LISTEN: begin
                if (rx_valid) begin
                    if (int'(r_q.seen) == IDX_LEN)  r_d.hlen  = rx_byte;
                    if (int'(r_q.seen) == IDX_CMD)  r_d.hcmd  = rx_byte;
                    if (int'(r_q.seen) == IDX_CODE) r_d.hcode = rx_byte;
                    if (r_q.seen != SEEN_MAX)       r_d.seen  = r_q.seen + 1'b1;
                end
                if (rx_end) begin
                    r_d.seen  = '0;
                    r_d.hlen  = 8'h00;
                    r_d.hcmd  = 8'h00;
                    r_d.hcode = 8'h00;
                    crc_clr   = 1'b1;
                    if (rx_crc_ok && dec_kind != RK_NONE) begin
                        r_d.st   = ST_SEND;
                        r_d.kind = dec_kind;
                        r_d.pos  = '0;
                        r_d.id   = id_value;
                    end else begin
                        r_d.rearm = 1'b1;
                    end
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    crc_en = (r_q.pos < gen_body);
                    if (r_q.pos == gen_last) begin
                        r_d.st = ST_WAIT;
                    end else begin
                        r_d.pos = r_q.pos + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (tx_done) begin
                    r_d.st    = ST_LISTEN;
                    r_d.kind  = RK_NONE;
                    r_d.seen  = '0;
                    r_d.rearm = 1'b1;
                end
            end
            default: begin
                r_d.st = ST_LISTEN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_LISTEN;
            r_q.kind  <= RK_NONE;
            r_q.pos   <= '0;
            r_q.id    <= '0;
            r_q.hlen  <= 8'h00;
            r_q.hcmd  <= 8'h00;
            r_q.hcode <= 8'h00;
            r_q.seen  <= '0;
            r_q.rearm <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid = (r_q.st == ST_SEND);
    assign tx_byte  = gen_byte;
    assign tx_last  = (r_q.st == ST_SEND) && (r_q.pos == gen_last);
    assign rx_rearm = r_q.rearm;

    // R7: a stalled byte is held
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last));

    // R2, R4: a reply always opens with one of the legal length bytes
    a_r2_first_byte_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_byte == 8'(LEN_SHORT) || tx_byte == 8'(LEN_LONG) || tx_byte == 8'(LEN_READ)));

    // R9: after the final byte is taken, nothing more is offered
    a_r9_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> !tx_valid);

    // R6: a re-arm is never issued while a reply is being offered
    a_r6_rearm_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rearm |-> !tx_valid);

endmodule

// File: tb/poll_read_responder_test.sv
`timescale 1ns/1ps
module poll_read_responder_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid;
    logic [7:0]  rx_byte;
    logic        rx_end;
    logic        rx_crc_ok;
    logic [63:0] id_value;
    logic        tx_ready;
    logic        tx_done;

    logic        a_tx_valid, a_tx_last, a_rx_rearm;
    logic [7:0]  a_tx_byte;
    logic        b_tx_valid, b_tx_last, b_rx_rearm;
    logic [7:0]  b_tx_byte;

    always #10 clk = ~clk;

    poll_read_responder uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .id_value(id_value),
        .tx_ready(tx_ready), .tx_done(tx_done), .tx_valid(a_tx_valid),
        .tx_byte(a_tx_byte), .tx_last(a_tx_last), .rx_rearm(a_rx_rearm)
    );

    poll_read_responder #(.SYSCODE_REPLY(1'b1)) uut_sc (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .id_value(id_value),
        .tx_ready(tx_ready), .tx_done(tx_done), .tx_valid(b_tx_valid),
        .tx_byte(b_tx_byte), .tx_last(b_tx_last), .rx_rearm(b_rx_rearm)
    );

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_b [0:39];
    logic [7:0] got_b [0:39];
    int exp_n;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            for (int k = 7; k >= 0; k--) begin
                if (c[15] ^ exp_b[i][k]) c = (c << 1) ^ 16'h1021;
                else                     c = c << 1;
            end
        end
        return c;
    endfunction

    task automatic push(input logic [7:0] v);
        exp_b[exp_n] = v;
        exp_n++;
    endtask

    // kind: 0 short poll, 1 poll with system code, 2 read block (R2 R3 R4 R5)
    task automatic build_reply(input int kind, input logic [63:0] id);
        logic [63:0] prm = 64'h00F1_0000_0001_4300;
        logic [15:0] c;
        exp_n = 0;
        push(kind == 0 ? 8'h12 : kind == 1 ? 8'h14 : 8'h1D);
        push(kind == 2 ? 8'h07 : 8'h01);
        for (int i = 0; i < 8; i++) push(id[63-8*i -: 8]);
        if (kind == 2) begin
            push(8'h00); push(8'h00); push(8'h01);
            for (int i = 0; i < 16; i++) push(8'(i));
        end else begin
            for (int i = 0; i < 8; i++) push(prm[63-8*i -: 8]);
            if (kind == 1) begin push(8'h88); push(8'hB4); end
        end
        c = ref_crc(exp_n);
        push(c[15:8]);
        push(c[7:0]);
    endtask

    // Feeds eight bytes then raises rx_end (left high for the caller)
    task automatic send_frame(input logic [7:0] len, input logic [7:0] cmd,
                              input logic [7:0] code, input bit ok);
        logic [7:0] fr [0:7];
        fr[0] = len; fr[1] = cmd; fr[2] = 8'hFF; fr[3] = 8'hFF;
        fr[4] = code; fr[5] = 8'h00; fr[6] = 8'h5A; fr[7] = 8'hA5;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = fr[i];
        end
        @(negedge clk);
        rx_valid  = 1'b0;
        rx_end    = 1'b1;
        rx_crc_ok = ok;
    endtask

    task automatic sample(input bit sel, output logic v, output logic [7:0] b, output logic l);
        v = sel ? b_tx_valid : a_tx_valid;
        b = sel ? b_tx_byte  : a_tx_byte;
        l = sel ? b_tx_last  : a_tx_last;
    endtask

    task automatic expect_reply(input bit sel, input int stall, input bit peer_quiet, input string req);
        logic v, l, rdy;
        logic [7:0] b, prev_b;
        bit prev_stall = 0;
        bit done_f = 0;
        int cnt = 0;
        int bad = -1;
        logic [63:0] saved = id_value;
        @(negedge clk);
        rx_end = 1'b0;
        rx_crc_ok = 1'b0;
        sample(sel, v, b, l);
        check(v === 1'b1 && b === exp_b[0], "R10 first byte", {v, b}, {1'b1, exp_b[0]});
        if (peer_quiet)
            check(a_rx_rearm === 1'b1 && a_tx_valid === 1'b0, "R3 default silent",
                  {a_rx_rearm, a_tx_valid}, 2'b10);
        prev_b = b;
        for (int cyc = 0; cyc < 200 && !done_f; cyc++) begin
            if (cyc > 0) @(negedge clk);
            sample(sel, v, b, l);
            if (prev_stall)
                check(v === 1'b1 && b === prev_b, "R7 hold on stall", {v, b}, {1'b1, prev_b});
            if (cyc == 2) id_value = ~saved;
            rdy = (stall == 0) ? 1'b1 : (stall == 1) ? (cyc % 3 != 2) : (cyc % 2 == 1);
            tx_ready = rdy;
            prev_stall = v && !rdy;
            prev_b = b;
            if (v && rdy) begin
                if (cnt < 40) got_b[cnt] = b;
                cnt++;
                if (l) done_f = 1;
            end
        end
        @(negedge clk);
        tx_ready = 1'b0;
        id_value = saved;
        sample(sel, v, b, l);
        check(v === 1'b0, "R9 idle after last", v, 0);
        for (int i = 0; i < exp_n && i < cnt; i++)
            if (bad < 0 && got_b[i] !== exp_b[i]) bad = i;
        if (cnt != exp_n) check(0, {req, " byte count"}, cnt, exp_n);
        else if (bad >= 0) check(0, {req, " reply byte"}, {bad, got_b[bad]}, {bad, exp_b[bad]});
        else check(1, req, 0, 0);
    endtask

    task automatic finish_tx(input bit sel, input bit with_frame);
        logic v, l;
        logic [7:0] b;
        if (with_frame) begin
            send_frame(8'd6, 8'h00, 8'h00, 1'b1);
            tx_done = 1'b1;
        end else begin
            @(negedge clk);
            tx_done = 1'b1;
        end
        @(negedge clk);
        tx_done = 1'b0;
        rx_end = 1'b0;
        rx_crc_ok = 1'b0;
        sample(sel, v, b, l);
        check((sel ? b_rx_rearm : a_rx_rearm) === 1'b1 && v === 1'b0, "R9 rearm on done",
              {(sel ? b_rx_rearm : a_rx_rearm), v}, 2'b10);
        repeat (2) begin
            @(negedge clk);
            sample(sel, v, b, l);
            check(v === 1'b0, "R9 frame during wait ignored", v, 0);
        end
    endtask

    task automatic expect_silence(input string req);
        @(negedge clk);
        rx_end = 1'b0;
        rx_crc_ok = 1'b0;
        check(a_rx_rearm === 1'b1 && a_tx_valid === 1'b0 && b_rx_rearm === 1'b1 && b_tx_valid === 1'b0,
              req, {a_rx_rearm, a_tx_valid, b_rx_rearm, b_tx_valid}, 4'b1010);
        repeat (2) begin
            @(negedge clk);
            check(a_tx_valid === 1'b0 && b_tx_valid === 1'b0, {req, " stays quiet"},
                  {a_tx_valid, b_tx_valid}, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] ids [0:3];
        ids[0] = 64'h0123_4567_89AB_CDEF;
        ids[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        ids[2] = 64'h0000_0000_0000_0000;
        ids[3] = 64'h8000_0000_0000_0001;
        rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00; rx_end = 1'b0; rx_crc_ok = 1'b0;
        id_value = ids[0]; tx_ready = 1'b0; tx_done = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        check(a_tx_valid === 1'b0 && a_rx_rearm === 1'b0, "R1 reset main", {a_tx_valid, a_rx_rearm}, 0);
        check(b_tx_valid === 1'b0 && b_rx_rearm === 1'b0, "R1 reset syscode", {b_tx_valid, b_rx_rearm}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R5 R8: short poll over several identifiers and stall patterns
        for (int k = 0; k < 4; k++) begin
            id_value = ids[k];
            build_reply(0, ids[k]);
            send_frame(8'd6, 8'h00, 8'h00, 1'b1);
            expect_reply(0, k % 3, 0, "R2 R5 R8 short poll");
            finish_tx(0, k == 1);
        end

        // R3: request code 1 on both variants, R6: codes 2 and 3
        for (int code = 1; code < 4; code++) begin
            send_frame(8'd6, 8'h00, 8'(code), 1'b1);
            if (code == 1) begin
                build_reply(1, id_value);
                expect_reply(1, 1, 1, "R3 R5 syscode poll");
                finish_tx(1, 0);
            end else begin
                expect_silence("R6 poll code");
            end
        end

        // R4: read block, length byte sweep around the boundary
        for (int len = 0; len < 10; len++) begin
            id_value = ids[len % 4];
            send_frame(8'(len), 8'h06, 8'h00, 1'b1);
            if (len > 5) begin
                build_reply(2, ids[len % 4]);
                expect_reply(0, len % 3, 0, "R4 R5 R8 read block");
                finish_tx(0, len == 8);
            end else begin
                expect_silence("R6 read length");
            end
        end

        // R6: unrecognised commands
        for (int c = 1; c < 16; c++) begin
            if (c != 6) begin
                send_frame(8'd6, 8'(c), 8'h00, 1'b1);
                expect_silence("R6 command");
            end
        end

        // R6: wrong poll length, bad CRC
        send_frame(8'd5, 8'h00, 8'h00, 1'b1);
        expect_silence("R6 poll length 5");
        send_frame(8'd7, 8'h00, 8'h00, 1'b1);
        expect_silence("R6 poll length 7");
        send_frame(8'd6, 8'h00, 8'h00, 1'b0);
        expect_silence("R6 bad crc poll");
        send_frame(8'd9, 8'h06, 8'h00, 1'b0);
        expect_silence("R6 bad crc read");

        // Recovery after the rejections
        id_value = ids[3];
        build_reply(0, ids[3]);
        send_frame(8'd6, 8'h00, 8'h00, 1'b1);
        expect_reply(0, 2, 0, "R2 after rejects");
        finish_tx(0, 1);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule